// File: doc/BRIEF.md
# Golomb Run-Length Bitstream Decoder

This block turns a Golomb-coded run-length stream back into the original bit sequence. Coded data arrives as fixed 16-bit packages over a valid/ready handshake. Each package is appended to a 48-bit shift buffer. The buffer holds three packages so that a codeword of up to 16 bits is always fully present before it is parsed. A parser reads each codeword in one cycle. It finds the quotient by counting the ones before the first zero, then reads a remainder tail whose width follows the compile-time divisor `M`. When `M` is not a power of two, the tail uses truncated binary coding.

Each codeword stands for a run length N = q*M + r. An expander emits that run as N zeros followed by a one, one bit per cycle, and a ready input can stall it. The end of a stream travels with its final package, together with a count of the valid bits in that package. The closing one of the stream's final run is the encoder's end marker, so it is never emitted. `out_last` marks the last real bit instead. Once the final bit has been delivered, the next stream may follow immediately.

Top module: `golomb_pkt_decoder`

## Requirements
- R1: `pkt_ready` is high only while the buffer holds 32 or fewer unconsumed bits and no final package is pending. It drops in the cycle after a package flagged `pkt_last` is accepted. After reset, `pkt_ready` is 1 and `out_valid` is 0.
- R2: Within a package, bit 15 is the earliest bit of the coded stream and bit 0 is the latest. Packages follow each other in acceptance order.
- R3: A codeword starts with q ones terminated by a single zero, and q is the quotient. No codeword is longer than 16 bits.
- R4: When `M` is a power of two, the zero is followed by exactly log2(M) tail bits, most significant first, which give the remainder r.
- R5: When `M` is not a power of two, let b = ceil(log2(M)) and t = 2^b - M. The parser reads b-1 bits first. If their value is below t, that value is r. Otherwise one more bit is read, and r is the b-bit value minus t.
- R6: Each codeword produces N = q*M + r zeros followed by a one on `out_bit`. Bits come out in stream order, and one bit is transferred in each cycle where `out_valid` and `out_ready` are both high.
- R7: A package with `pkt_last` high holds only `pkt_nbits` valid bits (1 to 16), taken from bit 15 downward. Its remaining low bits have no effect on the output.
- R8: The closing one of the stream's final run is not emitted. `out_last` is high on the last emitted bit, including the case where the final run has N = 0, and `out_valid` is low in the cycle after that bit transfers.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_last` hold their values into the next cycle.
- R10: After the last bit of a stream has transferred, the first package of a following stream is accepted and decoded with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_data | input | 16 | Coded package, bit 15 first in stream order |
| pkt_valid | input | 1 | Package present |
| pkt_last | input | 1 | This package ends the stream |
| pkt_nbits | input | 5 | Valid bits in a final package (1 to 16) |
| pkt_ready | output | 1 | Package accepted on this edge if valid |
| out_bit | output | 1 | Decoded bit |
| out_valid | output | 1 | `out_bit` is meaningful |
| out_last | output | 1 | Last decoded bit of the stream |
| out_ready | input | 1 | Consumer takes the bit on this edge |

## Verification
A wrong shift amount or a wrong buffer count misaligns every codeword that follows it. The error therefore shows up within one run as extra or missing zeros, or as a stray one, and the bench catches it by comparing the whole recovered pattern. A mistake in final-codeword detection shows up at the end of the stream: the marker one is emitted, `out_last` is missing or lands on the wrong bit, or `pkt_ready` never comes back for the next stream. Errors in the ready threshold or the stall hold appear within a few cycles, either as a fourth package accepted while the output is blocked or as an output that changes while stalled.

// File: rtl/golomb_dec_pkg.sv
package golomb_dec_pkg;

  // Width of the remainder tail for divisor m (ceil(log2 m)).
  function automatic int tail_width(input int m);
    return $clog2(m);
  endfunction

  // True when m is a power of two: plain binary tail, no truncation.
  function automatic bit divisor_is_pow2(input int m);
    return (m & (m - 1)) == 0;
  endfunction

endpackage

// File: rtl/gd_parse.sv
module gd_parse
  import golomb_dec_pkg::*;
#(
  parameter int PKT_W = 16,
  parameter int M     = 2,
  parameter int BUF_W = 48,
  parameter int CW    = 6,
  parameter int NW    = 6
) (
  input  logic [BUF_W-1:0] win,
  input  logic [CW-1:0]    cnt,
  input  logic             eos,
  output logic             code_ok,
  output logic             code_fin,
  output logic [NW-1:0]    code_n,
  output logic [CW-1:0]    code_len
);
  localparam int B   = tail_width(M);
  localparam int THR = (1 << B) - M;

  logic          found;
  logic [CW-1:0] q;
  logic [CW-1:0] tl;
  logic [NW-1:0] r;
  logic [BUF_W-1:0] sh;

  // Quotient: ones ahead of the first zero within one package window.
  always_comb begin
    found = 1'b0;
    q     = '0;
    for (int i = 0; i < PKT_W; i++) begin
      if (!found && !win[BUF_W-1-i]) begin
        found = 1'b1;
        q     = CW'(i);
      end
    end
  end

  assign sh = win << (q + CW'(1));

  generate
    if (divisor_is_pow2(M)) begin : g_pow2
      assign r  = NW'(sh[BUF_W-1 -: B]);
      assign tl = CW'(B);
    end else begin : g_trunc
      logic [B-2:0] t_short;
      assign t_short = sh[BUF_W-1 -: B-1];
      always_comb begin
        if ({1'b0, t_short} < B'(THR)) begin
          r  = NW'(t_short);
          tl = CW'(B - 1);
        end else begin
          r  = NW'(sh[BUF_W-1 -: B]) - NW'(THR);
          tl = CW'(B);
        end
      end
    end
  endgenerate

  assign code_len = q + CW'(1) + tl;
  assign code_n   = NW'(q) * NW'(M) + r;
  assign code_ok  = found && ((cnt >= CW'(PKT_W)) || (eos && cnt >= code_len));
  assign code_fin = eos && (cnt == code_len);

endmodule

// File: rtl/gd_buffer.sv
module gd_buffer #(
  parameter int PKT_W = 16,
  parameter int BUF_W = 48,
  parameter int CW    = 6,
  parameter int NBW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PKT_W-1:0] pkt_data,
  input  logic             pkt_valid,
  input  logic             pkt_last,
  input  logic [NBW-1:0]   pkt_nbits,
  output logic             pkt_ready,
  input  logic             take,
  input  logic [CW-1:0]    take_len,
  input  logic             eos_clr,
  output logic [BUF_W-1:0] bits,
  output logic [CW-1:0]    cnt,
  output logic             eos
);
  localparam int LIMIT = BUF_W - PKT_W;

  logic             accept;
  logic [CW-1:0]    keep_cnt, cnt_nx;
  logic [BUF_W-1:0] keep_bits, ins, bits_nx;
  logic [PKT_W-1:0] mask;
  logic             eos_nx;

  assign pkt_ready = !eos && (cnt <= CW'(LIMIT));
  assign accept    = pkt_valid && pkt_ready;

  always_comb begin
    keep_cnt  = take ? cnt - take_len : cnt;
    keep_bits = take ? bits << take_len : bits;
    mask      = pkt_last ? ~({PKT_W{1'b1}} >> pkt_nbits) : {PKT_W{1'b1}};
    ins       = {pkt_data & mask, {(BUF_W-PKT_W){1'b0}}} >> keep_cnt;
    bits_nx   = accept ? (keep_bits | ins) : keep_bits;
    cnt_nx    = accept ? keep_cnt + (pkt_last ? CW'(pkt_nbits) : CW'(PKT_W))
                       : keep_cnt;
    if (accept && pkt_last)  eos_nx = 1'b1;
    else if (eos_clr)        eos_nx = 1'b0;
    else                     eos_nx = eos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
      cnt  <= '0;
      eos  <= 1'b0;
    end else begin
      if (accept || take) begin
        bits <= bits_nx;
        cnt  <= cnt_nx;
      end
      eos <= eos_nx;
    end
  end

  // R1: the buffer never holds more than its three packages
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BUF_W));

  // R1: a final package closes the input until the stream drains
  a_r1_final_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && pkt_last) |=> !pkt_ready);

endmodule

// File: rtl/gd_expand.sv
module gd_expand #(
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_ok,
  input  logic          code_fin,
  input  logic [NW-1:0] code_n,
  input  logic          out_ready,
  output logic          take,
  output logic          done,
  output logic          out_bit,
  output logic          out_valid,
  output logic          out_last
);
  logic          act, fin;
  logic [NW-1:0] zcnt;
  logic          act_nx, fin_nx;
  logic [NW-1:0] zcnt_nx;
  logic          zero_ph, one_ph, end_empty;

  always_comb begin
    zero_ph   = act && (zcnt != '0);
    one_ph    = act && (zcnt == '0) && !fin;
    out_valid = zero_ph || (one_ph && code_ok);
    out_bit   = !zero_ph;
    out_last  = (zero_ph && fin && zcnt == NW'(1)) ||
                (one_ph && code_ok && code_fin && code_n == '0);
    take      = (!act && code_ok) || (one_ph && code_ok && out_ready);
    end_empty = take && act && code_fin && (code_n == '0);
    done      = (act && fin && zcnt == '0) ||
                (zero_ph && fin && zcnt == NW'(1) && out_ready) || end_empty;

    act_nx  = act;
    fin_nx  = fin;
    zcnt_nx = zcnt;
    if (zero_ph && out_ready) begin
      zcnt_nx = zcnt - NW'(1);
      if (fin && zcnt == NW'(1)) act_nx = 1'b0;
    end
    if (act && fin && zcnt == '0) act_nx = 1'b0;
    if (take) begin
      if (end_empty) begin
        act_nx = 1'b0;
      end else begin
        act_nx  = 1'b1;
        fin_nx  = code_fin;
        zcnt_nx = code_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      fin  <= 1'b0;
      zcnt <= '0;
    end else begin
      act  <= act_nx;
      fin  <= fin_nx;
      zcnt <= zcnt_nx;
    end
  end

  // R9: a stalled output holds steady
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

  // R8: nothing follows the last bit of a stream in the next cycle
  a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

endmodule

// File: rtl/golomb_pkt_decoder.sv
module golomb_pkt_decoder #(
  parameter int PKT_W = 16,
  parameter int M     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PKT_W-1:0]           pkt_data,
  input  logic                       pkt_valid,
  input  logic                       pkt_last,
  input  logic [$clog2(PKT_W+1)-1:0] pkt_nbits,
  output logic                       pkt_ready,
  output logic                       out_bit,
  output logic                       out_valid,
  output logic                       out_last,
  input  logic                       out_ready
);
  localparam int BUF_W = 3 * PKT_W;
  localparam int CW    = $clog2(BUF_W + 1);
  localparam int NBW   = $clog2(PKT_W + 1);
  localparam int NW    = $clog2(PKT_W * M + 1);

  logic [1:0]       rst_q;
  logic             rst_i_n;
  logic [BUF_W-1:0] bits;
  logic [CW-1:0]    cnt, code_len;
  logic             eos, code_ok, code_fin, take, done;
  logic [NW-1:0]    code_n;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  gd_buffer #(.PKT_W(PKT_W), .BUF_W(BUF_W), .CW(CW), .NBW(NBW)) u_buf (
    .clk(clk), .rst_n(rst_i_n),
    .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_last(pkt_last),
    .pkt_nbits(pkt_nbits), .pkt_ready(pkt_ready),
    .take(take), .take_len(code_len), .eos_clr(done),
    .bits(bits), .cnt(cnt), .eos(eos)
  );

  gd_parse #(.PKT_W(PKT_W), .M(M), .BUF_W(BUF_W), .CW(CW), .NW(NW)) u_parse (
    .win(bits), .cnt(cnt), .eos(eos),
    .code_ok(code_ok), .code_fin(code_fin), .code_n(code_n), .code_len(code_len)
  );

  gd_expand #(.NW(NW)) u_exp (
    .clk(clk), .rst_n(rst_i_n),
    .code_ok(code_ok), .code_fin(code_fin), .code_n(code_n),
    .out_ready(out_ready), .take(take), .done(done),
    .out_bit(out_bit), .out_valid(out_valid), .out_last(out_last)
  );

endmodule

// File: tb/sim_golomb_pkt_decoder.sv
`timescale 1ns/1ps
module sim_golomb_pkt_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pkt_data = '0;
  logic        pv0 = 1'b0, pv1 = 1'b0;
  logic        pkt_last = 1'b0;
  logic [4:0]  pkt_nbits = 5'd16;
  logic        out_ready = 1'b0;
  logic        rdy0, ob0, ov0, ol0, rdy1, ob1, ov1, ol1;

  int checks = 0, fails = 0;
  bit enc [0:1023];
  int enc_len;

  always #10 clk = ~clk;

  golomb_pkt_decoder #(.PKT_W(16), .M(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_data(pkt_data), .pkt_valid(pv0),
    .pkt_last(pkt_last), .pkt_nbits(pkt_nbits), .pkt_ready(rdy0),
    .out_bit(ob0), .out_valid(ov0), .out_last(ol0), .out_ready(out_ready));

  golomb_pkt_decoder #(.PKT_W(16), .M(3)) u1 (
    .clk(clk), .rst_n(rst_n), .pkt_data(pkt_data), .pkt_valid(pv1),
    .pkt_last(pkt_last), .pkt_nbits(pkt_nbits), .pkt_ready(rdy1),
    .out_bit(ob1), .out_valid(ov1), .out_last(ol1), .out_ready(out_ready));

  localparam int NV = 8;
  localparam logic [63:0] VP [NV] = '{
    64'hA5A5_0000_0000_0000, 64'hF0F0_F0F0_0000_0000, 64'h8000_0100_0000_0000,
    64'hF0F0_F0F0_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000,
    64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000};
  localparam int VL [NV] = '{16, 40, 36, 40, 64, 20, 64, 1};
  localparam int VM [NV] = '{2, 2, 3, 3, 2, 3, 3, 2};
  localparam bit VS [NV] = '{0, 1, 0, 1, 1, 0, 1, 0};

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(input bit b);
    enc[enc_len] = b;
    enc_len++;
  endtask

  task automatic push_code(input int n, input int m);
    int q, r, b, thr;
    q = n / m; r = n % m; b = $clog2(m);
    for (int k = 0; k < q; k++) push(1'b1);
    push(1'b0);
    if ((m & (m - 1)) == 0) begin
      for (int k = b - 1; k >= 0; k--) push(1'((r >> k) & 1));
    end else begin
      thr = (1 << b) - m;
      if (r < thr) for (int k = b - 2; k >= 0; k--) push(1'((r >> k) & 1));
      else         for (int k = b - 1; k >= 0; k--) push(1'(((r + thr) >> k) & 1));
    end
  endtask

  // Encoder model: runs over the pattern plus the end marker one
  task automatic encode(input logic [63:0] pat, input int len, input int m);
    int zc;
    enc_len = 0; zc = 0;
    for (int i = 0; i <= len; i++) begin
      if (i < len && !pat[63-i]) zc++;
      else begin push_code(zc, m); zc = 0; end
    end
  endtask

  task automatic send(input int sel, output bit closed_ok);
    closed_ok = 1'b1;
    for (int p = 0; p * 16 < enc_len; p++) begin
      @(negedge clk);
      for (int k = 0; k < 16; k++)
        pkt_data[15-k] = (p * 16 + k < enc_len) ? enc[p*16+k] : 1'b1;
      pkt_last  = ((p + 1) * 16 >= enc_len);
      pkt_nbits = 5'((enc_len - p * 16 > 16) ? 16 : enc_len - p * 16);
      if (sel == 0) pv0 = 1'b1; else pv1 = 1'b1;
      while (!(sel == 0 ? rdy0 : rdy1)) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    pv0 = 1'b0; pv1 = 1'b0; pkt_last = 1'b0;
    if ((sel == 0 ? rdy0 : rdy1) !== 1'b0) closed_ok = 1'b0;
  endtask

  task automatic collect(input int sel, input bit stall, output logic [63:0] got,
                         output int n, output int lastpos, output int hold_bad);
    bit v, b, l, pend, pb, pl, fin;
    int t;
    got = '0; n = 0; lastpos = -1; hold_bad = 0; pend = 0; fin = 0; t = 0;
    while (!fin && t < 4000) begin
      @(negedge clk);
      out_ready = stall ? (t % 3 != 2) : 1'b1;
      #1;
      v = sel == 0 ? ov0 : ov1;
      b = sel == 0 ? ob0 : ob1;
      l = sel == 0 ? ol0 : ol1;
      if (pend) begin
        if (!v || b != pb || l != pl) hold_bad++;
        pend = 0;
      end
      if (v && !out_ready) begin pend = 1; pb = b; pl = l; end
      if (v && out_ready) begin
        if (n < 64) got[63-n] = b;
        if (l) begin lastpos = n; fin = 1; end
        n++;
      end
      t++;
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] got, expv;
    int n, lastpos, hold_bad, acc;
    bit closed_ok, extra;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rdy0 === 1'b1 && ov0 === 1'b0, "R1 reset state ready/valid",
          {rdy0, ov0}, 2'b10);

    // Table walk: streams back to back, no reset in between (R10)
    for (int v = 0; v < NV; v++) begin
      int sel;
      sel = (VM[v] == 2) ? 0 : 1;
      encode(VP[v], VL[v], VM[v]);
      fork
        send(sel, closed_ok);
        collect(sel, VS[v], got, n, lastpos, hold_bad);
      join
      expv = (VL[v] == 64) ? VP[v] : (VP[v] & ~(64'hFFFF_FFFF_FFFF_FFFF >> VL[v]));
      // R2 R3 R4 R5 R6 R7: recovered pattern, padding ignored
      check(got === expv, $sformatf("R2/R3/R4/R5/R6/R7 vector %0d bits m=%0d", v, VM[v]),
            got, expv);
      // R8 R10: count and last flag position, marker one removed
      check(n == VL[v] && lastpos == VL[v] - 1,
            $sformatf("R8/R10 vector %0d count/last", v), n, VL[v]);
      check(closed_ok, $sformatf("R1 vector %0d ready low after final package", v),
            closed_ok, 1);
      if (VS[v])
        check(hold_bad == 0, $sformatf("R9 vector %0d stall hold", v), hold_bad, 0);
      extra = 0;
      out_ready = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        if ((sel == 0 ? ov0 : ov1) !== 1'b0) extra = 1;
      end
      out_ready = 1'b0;
      check(!extra, $sformatf("R8 vector %0d no bit after last", v), extra, 0);
    end

    // R1: ready threshold with output blocked, all-ones stream of 2-bit codes
    out_ready = 1'b0;
    acc = 0;
    @(negedge clk);
    pkt_data = 16'h0000; pkt_last = 1'b0; pv0 = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (rdy0) acc++;
    end
    // first negedge above already saw cnt=0, count it separately
    pv0 = 1'b0;
    check(rdy0 === 1'b0, "R1 ready low above 32 bits", rdy0, 0);
    check(acc == 2, "R1 packages accepted after the first", acc, 2);

    // R1: reset in mid-stream returns to the reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rdy0 === 1'b1 && ov0 === 1'b0, "R1 state after mid-stream reset",
          {rdy0, ov0}, 2'b10);

    // R10: a stream decodes normally after that reset
    encode(64'hC300_0000_0000_0000, 12, 2);
    fork
      send(0, closed_ok);
      collect(0, 1'b0, got, n, lastpos, hold_bad);
    join
    check(got === 64'hC300_0000_0000_0000 && n == 12, "R10 stream after reset",
          got, 64'hC300_0000_0000_0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule